// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Sequencer

This block drives one chip-select of an asynchronous external memory bus carrying an 8-bit NAND device. Each access runs through a setup phase, a strobe phase and a hold phase. The length of each phase comes from a configuration word and can differ between reads and writes. A turnaround gap follows every access before the next one can begin. Chip select, address and write data are presented for the whole access. The write strobe or the read strobe is asserted only during the strobe phase. Read data is captured on the last strobe cycle.

The host side uses a level request with a one-cycle acknowledge. The host holds `req` together with the direction, the address, the write byte and two latch flags until `ack` pulses. The two latch flags mark the byte as a command byte or an address byte on the device's latch lines. If the host keeps `req` high after `ack`, the next access starts as soon as the turnaround has elapsed. The device ready/busy pin is synchronised and shown as a status bit.

Top module: `amem_strobe_seq`

## Requirements
- R1: While reset is low and after it is released with no request, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1. `ack`, `mem_dout_en`, `mem_cle`, `mem_ale` and `stat_ready` are 0.
- R2: Phase lengths are taken from these bits of the configuration word:
  - write setup: bits 29..26
  - write strobe: bits 25..20
  - write hold: bits 19..17
  - read setup: bits 16..13
  - read strobe: bits 12..7
  - read hold: bits 6..4
  - turnaround: bits 3..2

  A field value N gives N+1 clock cycles in its phase. A value of 0 gives one cycle.
- R3: In a write, `mem_cs_n` is low from the first setup cycle through the last hold cycle. `mem_we_n` is low only in the strobe cycles. `mem_addr`, `mem_dout` and `mem_dout_en`=1 hold the request's values during the whole access.
- R4: In a read, `mem_oe_n` is low only in the strobe cycles and `mem_dout_en` stays 0. `rdata` equals the value on `mem_din` during the last strobe cycle and keeps it afterwards.
- R5: `ack` is high for exactly one cycle, the cycle after the last hold cycle. `mem_cs_n` is 1 in that cycle.
- R6: After an access, `mem_cs_n` stays 1 for at least turnaround+1 cycles. When a request is already waiting, the next setup begins exactly after turnaround+1 cycles.
- R7: `mem_cle` and `mem_ale` follow the request's command and address flags while chip select is low, and are 0 while it is high.
- R8: The configuration is captured when a request is accepted. A change of `cfg_word` during an access does not alter that access's phase lengths.
- R9: `stat_ready` shows the level of `mem_rdy` two clock edges after it was applied.
- R10: The write and read strobes are never low together, and neither is low while `mem_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 28 | Bits 29..2 of the timing configuration word |
| req | input | 1 | Access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cle | input | 1 | Mark the byte as a command byte |
| req_ale | input | 1 | Mark the byte as an address byte |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read byte |
| stat_ready | output | 1 | Synchronised device ready level |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_cle | output | 1 | Command latch line |
| mem_ale | output | 1 | Address latch line |
| mem_addr | output | ADDR_W | Address to the device |
| mem_dout | output | DATA_W | Write data to the device |
| mem_dout_en | output | 1 | Write data output enable |
| mem_din | input | DATA_W | Read data from the device |
| mem_rdy | input | 1 | Device ready/busy pin |

## Verification
With a turnaround field of 0, the single turnaround cycle is also the cycle that carries `ack`. A request still held there is accepted in that same cycle, so the completion of one access and the acceptance of the next coincide. The bench provokes this by leaving `req` high across `ack` with new request fields. It then checks that the gap with chip select high is exactly one cycle, that the second access has its own correct phase lengths and data, and that `ack` never stretches over two cycles. The same back-to-back pattern is repeated with turnaround 3 to confirm the four-cycle gap.

// File: rtl/amem_seq_pkg.sv
package amem_seq_pkg;

    // Configuration word bit range used by the sequencer
    localparam int CFG_HI   = 29;
    localparam int CFG_LO   = 2;

    // Field widths
    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 6;
    localparam int HOLD_W   = 3;
    localparam int TURN_W   = 2;

    // Field positions inside the configuration word
    localparam int WSU_LSB  = 26;
    localparam int WST_LSB  = 20;
    localparam int WHO_LSB  = 17;
    localparam int RSU_LSB  = 13;
    localparam int RST_LSB  = 7;
    localparam int RHO_LSB  = 4;
    localparam int TA_LSB   = 2;

    // Phase counter wide enough for the widest field
    localparam int CNT_W = (STROBE_W > SETUP_W) ? STROBE_W : SETUP_W;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
    } dir_timing_t;

    typedef struct packed {
        dir_timing_t         wr;
        dir_timing_t         rd;
        logic [TURN_W-1:0]   turn;
    } timing_t;

endpackage

// File: rtl/amem_cfg_unpack.sv
module amem_cfg_unpack
    import amem_seq_pkg::*;
(
    input  logic [CFG_HI:CFG_LO] cfg_word,
    output timing_t              tim
);

    always_comb begin
        tim.wr.setup  = cfg_word[WSU_LSB +: SETUP_W];
        tim.wr.strobe = cfg_word[WST_LSB +: STROBE_W];
        tim.wr.hold   = cfg_word[WHO_LSB +: HOLD_W];
        tim.rd.setup  = cfg_word[RSU_LSB +: SETUP_W];
        tim.rd.strobe = cfg_word[RST_LSB +: STROBE_W];
        tim.rd.hold   = cfg_word[RHO_LSB +: HOLD_W];
        tim.turn      = cfg_word[TA_LSB +: TURN_W];
    end

endmodule

// File: rtl/amem_level_sync.sv
module amem_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic lvl_out
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = lvl_in;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], lvl_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl_out = sh_q[STAGES-1];

endmodule

// File: rtl/amem_seq_core.sv
module amem_seq_core
    import amem_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_t           tim,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_cle,
    input  logic              req_ale,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output phase_e            phase,
    output logic              xf_write,
    output logic              xf_cle,
    output logic              xf_ale,
    output logic [ADDR_W-1:0] xf_addr,
    output logic [DATA_W-1:0] xf_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        dir_timing_t       cur;
        logic [TURN_W-1:0] turn;
        logic              wr;
        logic              cle;
        logic              ale;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } state_t;

    state_t      d, q;
    dir_timing_t sel;
    logic        accept;
    logic        last;

    always_comb begin
        d      = q;
        d.ack  = 1'b0;
        accept = 1'b0;
        sel    = req_write ? tim.wr : tim.rd;
        last   = (q.cnt == '0);

        case (q.phase)
            PH_IDLE: begin
                if (req) accept = 1'b1;
            end
            PH_SETUP: begin
                if (last) begin
                    d.phase = PH_STROBE;
                    d.cnt   = CNT_W'(q.cur.strobe);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (last) begin
                    d.phase = PH_HOLD;
                    d.cnt   = CNT_W'(q.cur.hold);
                    if (!q.wr) d.rdata = mem_din;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (last) begin
                    d.phase = PH_TURN;
                    d.cnt   = CNT_W'(q.turn);
                    d.ack   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (last) begin
                    if (req) accept  = 1'b1;
                    else     d.phase = PH_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (accept) begin
            d.phase = PH_SETUP;
            d.cur   = sel;
            d.cnt   = CNT_W'(sel.setup);
            d.turn  = tim.turn;
            d.wr    = req_write;
            d.cle   = req_cle;
            d.ale   = req_ale;
            d.addr  = req_addr;
            d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase    = q.phase;
    assign xf_write = q.wr;
    assign xf_cle   = q.cle;
    assign xf_ale   = q.ale;
    assign xf_addr  = q.addr;
    assign xf_wdata = q.wdata;
    assign rdata    = q.rdata;
    assign ack      = q.ack;

endmodule

// File: rtl/amem_pin_drive.sv
module amem_pin_drive
    import amem_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  phase_e            phase,
    input  logic              xf_write,
    input  logic              xf_cle,
    input  logic              xf_ale,
    input  logic [ADDR_W-1:0] xf_addr,
    input  logic [DATA_W-1:0] xf_wdata,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_cle,
    output logic              mem_ale,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en
);

    logic active;
    logic strobing;

    always_comb begin
        active      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobing    = (phase == PH_STROBE);
        mem_cs_n    = !active;
        mem_we_n    = !(strobing && xf_write);
        mem_oe_n    = !(strobing && !xf_write);
        mem_cle     = active && xf_cle;
        mem_ale     = active && xf_ale;
        mem_addr    = xf_addr;
        mem_dout    = xf_wdata;
        mem_dout_en = active && xf_write;
    end

endmodule

// File: rtl/amem_strobe_seq.sv
module amem_strobe_seq
    import amem_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [29:2]       cfg_word,
    input  logic              req,
    input  logic              req_write,
    input  logic              req_cle,
    input  logic              req_ale,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              stat_ready,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_cle,
    output logic              mem_ale,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    input  logic              mem_rdy
);

    timing_t           tim;
    phase_e            phase;
    logic              xf_write;
    logic              xf_cle;
    logic              xf_ale;
    logic [ADDR_W-1:0] xf_addr;
    logic [DATA_W-1:0] xf_wdata;

    amem_cfg_unpack u_unpack (
        .cfg_word (cfg_word),
        .tim      (tim)
    );

    amem_seq_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tim       (tim),
        .req       (req),
        .req_write (req_write),
        .req_cle   (req_cle),
        .req_ale   (req_ale),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (mem_din),
        .phase     (phase),
        .xf_write  (xf_write),
        .xf_cle    (xf_cle),
        .xf_ale    (xf_ale),
        .xf_addr   (xf_addr),
        .xf_wdata  (xf_wdata),
        .rdata     (rdata),
        .ack       (ack)
    );

    amem_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase       (phase),
        .xf_write    (xf_write),
        .xf_cle      (xf_cle),
        .xf_ale      (xf_ale),
        .xf_addr     (xf_addr),
        .xf_wdata    (xf_wdata),
        .mem_cs_n    (mem_cs_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_cle     (mem_cle),
        .mem_ale     (mem_ale),
        .mem_addr    (mem_addr),
        .mem_dout    (mem_dout),
        .mem_dout_en (mem_dout_en)
    );

    amem_level_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (mem_rdy),
        .lvl_out (stat_ready)
    );

endmodule

// File: rtl/amem_strobe_seq_chk.sv
module amem_strobe_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_cle,
    input logic              mem_ale,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dout_en
);

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R5
    AST_ACK_CS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) ack |-> mem_cs_n); // R5
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n || !mem_oe_n) |-> !mem_cs_n); // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n)); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
    AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_dout_en); // R3
    AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> !mem_dout_en); // R4
    AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> !(mem_cle || mem_ale)); // R7
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> !mem_cs_n); // R2
    AST_HOLD_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |-> !mem_cs_n); // R2

endmodule

bind amem_strobe_seq amem_strobe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_cle     (mem_cle),
    .mem_ale     (mem_ale),
    .mem_addr    (mem_addr),
    .mem_dout_en (mem_dout_en)
);

// File: tb/amem_strobe_seq_test.sv
`timescale 1ns/1ps
module amem_strobe_seq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_full;
    logic [29:2] cfg_word;
    logic        req, req_write, req_cle, req_ale;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        ack;
    logic [7:0]  rdata;
    logic        stat_ready;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_cle, mem_ale, mem_dout_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;
    logic        mem_rdy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic        nxt_wr, nxt_cl, nxt_al;
    logic [15:0] nxt_ad;
    logic [7:0]  nxt_dt;

    assign cfg_word = cfg_full[29:2];

    always #2 clk = ~clk;

    amem_strobe_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .req(req), .req_write(req_write), .req_cle(req_cle), .req_ale(req_ale),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ack(ack), .rdata(rdata), .stat_ready(stat_ready),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_cle(mem_cle), .mem_ale(mem_ale), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_rdy(mem_rdy)
    );

    function automatic int fld(input logic [31:0] c, input int lsb, input int w);
        return int'((c >> lsb) & ((32'd1 << w) - 1));
    endfunction

    function automatic logic [31:0] mk_cfg(input int ws, input int wst, input int wh,
                                           input int rs, input int rst, input int rh, input int ta);
        return (32'(ws) << 26) | (32'(wst) << 20) | (32'(wh) << 17) |
               (32'(rs) << 13) | (32'(rst) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one access and checks phase lengths, pins and completion
    task automatic run_access(input bit wr, input bit cl, input bit al,
                              input logic [15:0] ad, input logic [7:0] dt,
                              input bit fresh, input bit keep,
                              input bit swap, input logic [31:0] swap_cfg,
                              input string rq);
        logic [31:0] c = cfg_full;
        int e_su = wr ? fld(c, 26, 4) + 1 : fld(c, 13, 4) + 1;
        int e_st = wr ? fld(c, 20, 6) + 1 : fld(c, 7, 6) + 1;
        int e_ho = wr ? fld(c, 17, 3) + 1 : fld(c, 4, 3) + 1;
        int pre = 0, str = 0, post = 0, late = 0, bad = 0, guard = 0;
        bit seen = 0, done = 0;
        if (fresh) begin
            req_write = wr; req_cle = cl; req_ale = al;
            req_addr = ad; req_wdata = dt; req = 1'b1;
            @(negedge clk);
        end
        mem_din = ~dt;
        while (!done && guard < 1000) begin
            if (ack) begin
                done = 1;
                if (!wr) chk("R4", "read data", int'(rdata), int'(dt));
                if (keep) begin
                    req_write = nxt_wr; req_cle = nxt_cl; req_ale = nxt_al;
                    req_addr = nxt_ad; req_wdata = nxt_dt;
                end else begin
                    req = 1'b0;
                end
            end else if (!mem_cs_n) begin
                if (wr ? !mem_oe_n : !mem_we_n) bad++;
                if (mem_addr !== ad || mem_cle !== cl || mem_ale !== al || mem_dout_en !== wr) bad++;
                if (wr && mem_dout !== dt) bad++;
                if (wr ? !mem_we_n : !mem_oe_n) begin
                    str++; seen = 1;
                end else if (!seen) begin
                    pre++;
                    if (swap && pre == 1) cfg_full = swap_cfg;
                end else begin
                    post++;
                end
                mem_din = (!wr && seen && post == 0 && str == e_st) ? dt : ~dt;
            end else if (seen) begin
                late++;
            end
            if (!done) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(rq, "ack seen", int'(done), 1);
        chk("R2", $sformatf("%s setup cycles", rq), pre, e_su);
        chk("R2", $sformatf("%s strobe cycles", rq), str, e_st);
        chk("R2", $sformatf("%s hold cycles", rq), post, e_ho);
        chk(rq, "pin mismatches during access", bad, 0);
        chk("R5", "idle cycles between hold and ack", late, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req = 1'b0; req_write = 1'b0; req_cle = 1'b0; req_ale = 1'b0;
        req_addr = '0; req_wdata = '0; mem_din = '0; mem_rdy = 1'b1;
        cfg_full = mk_cfg(1, 3, 1, 1, 5, 1, 3);
        idle(4);
        chk("R1", "cs_n in reset", int'(mem_cs_n), 1);
        chk("R1", "we_n/oe_n in reset", int'({mem_we_n, mem_oe_n}), 3);
        chk("R1", "ack/dout_en in reset", int'({ack, mem_dout_en}), 0);
        chk("R1", "cle/ale/stat in reset", int'({mem_cle, mem_ale, stat_ready}), 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1", "cs_n idle after reset", int'(mem_cs_n), 1);
        chk("R1", "ack idle after reset", int'(ack), 0);
    endtask

    task automatic t_example();
        cfg_full = mk_cfg(1, 3, 1, 1, 5, 1, 3);
        run_access(1, 1, 0, 16'h00A5, 8'h70, 1, 0, 0, '0, "R3");
        chk("R5", "cs_n released at ack", int'(mem_cs_n), 1);
        idle(6);
        run_access(0, 0, 0, 16'h1203, 8'h5A, 1, 0, 0, '0, "R4");
        idle(6);
    endtask

    task automatic t_latch_flags();
        cfg_full = mk_cfg(2, 1, 0, 0, 2, 2, 1);
        run_access(1, 0, 1, 16'h0011, 8'h33, 1, 0, 0, '0, "R7");
        idle(4);
        chk("R7", "cle/ale low while idle", int'({mem_cle, mem_ale}), 0);
        run_access(1, 1, 0, 16'h0022, 8'hFF, 1, 0, 0, '0, "R7");
        idle(4);
    endtask

    task automatic t_extremes();
        cfg_full = mk_cfg(0, 0, 0, 0, 0, 0, 0);
        run_access(1, 0, 0, 16'hBEEF, 8'h81, 1, 0, 0, '0, "R3");
        idle(4);
        run_access(0, 0, 0, 16'hBEF0, 8'h18, 1, 0, 0, '0, "R4");
        idle(4);
        cfg_full = mk_cfg(15, 63, 7, 15, 63, 7, 3);
        run_access(0, 0, 0, 16'hFFFF, 8'hC3, 1, 0, 0, '0, "R4");
        idle(6);
        run_access(1, 0, 0, 16'h0000, 8'h3C, 1, 0, 0, '0, "R3");
        idle(6);
    endtask

    task automatic t_back_to_back(input int ta);
        int gap = 0, g = 0;
        cfg_full = mk_cfg(1, 2, 1, 2, 3, 0, ta);
        nxt_wr = 1'b0; nxt_cl = 1'b0; nxt_al = 1'b0; nxt_ad = 16'h0BEE; nxt_dt = 8'h96;
        run_access(1, 0, 1, 16'h1234, 8'hA5, 1, 1, 0, '0, "R3");
        while (mem_cs_n && g < 100) begin
            gap++; g++;
            @(negedge clk);
        end
        chk("R6", $sformatf("turnaround gap ta=%0d", ta), gap, ta + 1);
        run_access(0, 0, 0, 16'h0BEE, 8'h96, 0, 0, 0, '0, "R4");
        idle(8);
    endtask

    task automatic t_cfg_swap();
        cfg_full = mk_cfg(2, 4, 2, 2, 4, 2, 1);
        run_access(1, 0, 0, 16'h0400, 8'h44, 1, 0, 1, mk_cfg(9, 20, 6, 9, 20, 6, 0), "R8");
        idle(4);
        cfg_full = mk_cfg(2, 4, 2, 3, 6, 1, 1);
        run_access(0, 0, 0, 16'h0401, 8'h45, 1, 0, 1, mk_cfg(0, 0, 0, 0, 0, 0, 0), "R8");
        idle(4);
    endtask

    task automatic t_status();
        mem_rdy = 1'b0;
        @(negedge clk);
        chk("R9", "ready after one edge", int'(stat_ready), 1);
        @(negedge clk);
        chk("R9", "busy after two edges", int'(stat_ready), 0);
        mem_rdy = 1'b1;
        @(negedge clk);
        chk("R9", "busy after one edge", int'(stat_ready), 0);
        @(negedge clk);
        chk("R9", "ready after two edges", int'(stat_ready), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_example();
        t_latch_flags();
        t_extremes();
        t_back_to_back(3);
        t_back_to_back(0);
        t_cfg_swap();
        t_status();
        finish_run();
    end

    initial begin
        #600000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule